// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Controller

The controller polls a small set of temperature-sensor ADC channels without software help. A two-level timer (a clock prescaler feeding a period counter) starts a scan round. In each round the channels are requested one after another. Each returned code is optionally inverted, masked to the data width of the chosen variant, and stored. The stored value is then compared against two per-channel limits: an alarm limit and a shutdown limit.

Both comparisons are debounced over consecutive samples, each with its own count. A debounced alarm sets a pending bit that software acknowledges through the register bus, and an interrupt line reports enabled pending alarms. A debounced shutdown latches until reset. It drives one or both shutdown pins (a GPIO-bound pin and a reset-unit pin) at a programmable active level. While any channel reads hot, rounds use a shorter interval.

Software reaches the block through a simple single-cycle register bus whose read data is registered. Configuration, readback of the last samples and interrupt handling all go through this bus.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset: the pending register reads 0 and irq is 0. Both shutdown pins sit at 1, the inactive level for the default active-low polarity. Auto control (0x04) reads 0, the alarm debounce register (0x60) reads 4, and no ADC request is issued.
- R2: While auto control bit 0 is set, each round requests channels 0 to NUM_CH-1 in ascending order. Each returned code is stored in the data register at 0x20+4*ch, masked to 10 bits in the default variant and to 12 bits in the wide variant.
- R3: With auto control bit 1 set, the stored value is 1024 minus the low 10 bits of the raw code, masked to the data width.
- R4: Rounds start every N ticks of TICK_DIV clocks, where N is the normal period register (0x68). If the previous sample of any channel exceeded that channel's alarm limit (0x30+4*ch) or shutdown limit (0x40+4*ch), N is taken from the fast period register (0x6C) instead.
- R5: With HOT_RISING=1, a sample exceeds a limit only when it is strictly greater than the limit. A sample equal to the limit counts as not exceeding.
- R6: Pending bit ch of register 0x0C is set on the sample at which the run of consecutive alarm-exceeding samples reaches the value in 0x60. Any sample that does not exceed the limit restarts the run from zero.
- R7: irq goes high one cycle after a pending bit ch is set while bit ch of interrupt enable (0x08) is set. Pending bits whose enable is clear never raise irq.
- R8: Writing 0x0C with bit ch at 0 clears pending bit ch; writing it with bit ch at 1 leaves it set. Bit 16 of 0x0C (bit 8 in the wide variant) reads 1 once any shutdown has latched, and writes do not change it.
- R9: When auto control bit 4+ch is set, a channel shutdown latches after the run of consecutive shutdown-exceeding samples reaches the value in 0x64. It stays latched until reset, even after cooler samples. With bit 4+ch clear, channel ch never latches.
- R10: Interrupt enable bit 4+ch routes a latched channel shutdown to shut_gpio, and bit 8+ch routes it to shut_reset. A pin with no latched routed channel stays at its inactive level.
- R11: Auto control bit 8 set makes both shutdown pins active-high (inactive 0). Bit 8 clear makes them active-low (inactive 1).
- R12: Clearing auto control bit 0 stops ADC requests and keeps the stored data. It also clears the debounce runs and the fast-period state, so after re-enable the first round waits a full normal period and a debounce needs its full count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| adc_req | output | 1 | Conversion request pulse |
| adc_chan | output | CH_W | Channel of the current request |
| adc_valid | input | 1 | ADC result strobe |
| adc_code | input | 12 | Raw ADC code |
| irq | output | 1 | Alarm interrupt, level |
| shut_gpio | output | 1 | Shutdown output toward the GPIO path |
| shut_reset | output | 1 | Shutdown output toward the reset unit |

## Verification
Two situations are hard to reach from the ports. One is a debounce run that is broken by a single cool sample. The other is a run that is cleared by disabling the scan, and each must be shown not to fire early. The bench drives the ADC stub, whose per-channel codes can change only between rounds, and it counts the stub's answers, so every code change lands on a known round boundary. The bench measures round intervals from the timestamps of the stub's channel-0 answers, which shows the switch between normal and fast periods exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADC_W = 12;
  localparam int BUS_W = 32;

  // byte offsets of fixed registers
  localparam logic [7:0] A_USER   = 8'h00;
  localparam logic [7:0] A_AUTO   = 8'h04;
  localparam logic [7:0] A_IEN    = 8'h08;
  localparam logic [7:0] A_PEND   = 8'h0C;
  localparam logic [7:0] A_DEB_AL = 8'h60;
  localparam logic [7:0] A_DEB_SH = 8'h64;
  localparam logic [7:0] A_PER_N  = 8'h68;
  localparam logic [7:0] A_PER_F  = 8'h6C;

  // per-channel register groups: upper address nibble
  localparam logic [3:0] G_DATA  = 4'h2;
  localparam logic [3:0] G_ALTHR = 4'h3;
  localparam logic [3:0] G_SHTHR = 4'h4;

  // bit positions software depends on
  localparam int B_RUN   = 0;
  localparam int B_INV   = 1;
  localparam int B_SHCHK = 4;
  localparam int B_POLH  = 8;
  localparam int B_R_IO  = 4;
  localparam int B_R_RU  = 8;

  typedef enum logic [0:0] {SQ_IDLE, SQ_WAIT} seq_state_e;

  function automatic logic [7:0] chan_addr(input logic [3:0] grp, input int c);
    logic [1:0] idx;
    idx = c[1:0];
    return {grp, idx, 2'b00};
  endfunction
endpackage

// File: rtl/tsc_ticker.sv
module tsc_ticker #(
  parameter int TICK_DIV = 4,
  parameter int PER_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel_fast,
  input  logic             busy,
  input  logic [PER_W-1:0] per_norm,
  input  logic [PER_W-1:0] per_fast,
  output logic             start
);
  localparam int PC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PC_W-1:0]  pc;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] lim;
  logic             tick;
  logic             due;

  assign tick = (pc == PC_W'(TICK_DIV - 1));
  assign lim  = sel_fast ? per_fast : per_norm;
  assign due  = (({1'b0, cnt} + 1'b1) >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc    <= '0;
      cnt   <= '0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      pc    <= tick ? '0 : pc + 1'b1;
      if (tick) begin
        if (due) begin
          cnt   <= '0;
          start <= !busy;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
  import tsc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            start,
  input  logic            adc_valid,
  output logic            adc_req,
  output logic [CH_W-1:0] cur_ch,
  output logic            smp_v,
  output logic            busy
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state   <= SQ_IDLE;
      adc_req <= 1'b0;
      cur_ch  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          adc_req <= 1'b0;
          if (start) begin
            adc_req <= 1'b1;
            cur_ch  <= '0;
            state   <= SQ_WAIT;
          end
        end
        default: begin
          adc_req <= 1'b0;
          if (adc_valid) begin
            if (cur_ch == CH_W'(NUM_CH - 1)) begin
              state <= SQ_IDLE;
            end else begin
              cur_ch  <= cur_ch + 1'b1;
              adc_req <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign smp_v = (state == SQ_WAIT) && adc_valid;
  assign busy  = (state != SQ_IDLE);
endmodule

// File: rtl/tsc_chan.sv
module tsc_chan
  import tsc_pkg::*;
#(
  parameter int DW         = 10,
  parameter int DEB_W      = 8,
  parameter int HOT_RISING = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             smp_v,
  input  logic [ADC_W-1:0] raw,
  input  logic             inv,
  input  logic [DW-1:0]    al_thr,
  input  logic [DW-1:0]    sh_thr,
  input  logic [DEB_W-1:0] al_deb,
  input  logic [DEB_W-1:0] sh_deb,
  input  logic             sh_chk,
  output logic [DW-1:0]    data,
  output logic             hot,
  output logic             al_evt,
  output logic             sh_lat
);
  logic [ADC_W-1:0] conv;
  logic [DW-1:0]    nd;
  logic             al_hit, sh_hit;
  logic [DEB_W-1:0] al_cnt, sh_cnt, al_nxt, sh_nxt;

  function automatic logic hotter(input logic [DW-1:0] v, input logic [DW-1:0] lim);
    return (HOT_RISING != 0) ? (v > lim) : (v < lim);
  endfunction

  assign conv   = inv ? (ADC_W'(1024) - {{(ADC_W-10){1'b0}}, raw[9:0]}) : raw;
  assign nd     = conv[DW-1:0];
  assign al_hit = hotter(nd, al_thr);
  assign sh_hit = hotter(nd, sh_thr);
  assign al_nxt = al_hit ? ((al_cnt == '1) ? al_cnt : al_cnt + 1'b1) : '0;
  assign sh_nxt = sh_hit ? ((sh_cnt == '1) ? sh_cnt : sh_cnt + 1'b1) : '0;
  assign al_evt = smp_v && al_hit && (al_nxt >= al_deb);

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      hot    <= 1'b0;
      al_cnt <= '0;
      sh_cnt <= '0;
      sh_lat <= 1'b0;
    end else begin
      if (smp_v && sh_chk && sh_hit && (sh_nxt >= sh_deb)) sh_lat <= 1'b1;
      if (!run) begin
        al_cnt <= '0;
        sh_cnt <= '0;
        hot    <= 1'b0;
      end else if (smp_v) begin
        data   <= nd;
        al_cnt <= al_nxt;
        sh_cnt <= sh_nxt;
        hot    <= al_hit || sh_hit;
      end
    end
  end
endmodule

// File: rtl/thermal_scan_ctrl.sv
module thermal_scan_ctrl
  import tsc_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int WIDE_DATA    = 0,
  parameter int HOT_RISING   = 1,
  parameter int TICK_DIV     = 4,
  parameter int PER_W        = 16,
  parameter int DEB_W        = 8,
  parameter int DEF_PER_NORM = 250,
  parameter int DEF_PER_FAST = 50,
  parameter int DEF_DEB      = 4,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             adc_req,
  output logic [CH_W-1:0]  adc_chan,
  input  logic             adc_valid,
  input  logic [11:0]      adc_code,
  output logic             irq,
  output logic             shut_gpio,
  output logic             shut_reset
);
  localparam int DW       = (WIDE_DATA != 0) ? 12 : 10;
  localparam int STAT_BIT = (WIDE_DATA != 0) ? 8 : 16;
  localparam logic [DW-1:0] THR_RST = (HOT_RISING != 0) ? '1 : '0;

  // configuration state
  logic [BUS_W-1:0]  user_r;
  logic              auto_en, auto_inv, pol_high;
  logic [NUM_CH-1:0] sh_chk, al_ien, rt_io, rt_ru;
  logic [DEB_W-1:0]  deb_al, deb_sh;
  logic [PER_W-1:0]  per_n, per_f;
  logic [DW-1:0]     al_thr [NUM_CH];
  logic [DW-1:0]     sh_thr [NUM_CH];

  // status and datapath
  logic [NUM_CH-1:0] pend, al_evt, sh_lat, hot, ch_smp;
  logic [DW-1:0]     ch_data [NUM_CH];
  logic              start, busy, smp_v;
  logic [BUS_W-1:0]  rd_mux;
  logic              wr_en, rd_en;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  tsc_ticker #(.TICK_DIV(TICK_DIV), .PER_W(PER_W)) u_ticker (
    .clk(clk), .rst(rst), .run(auto_en), .sel_fast(|hot), .busy(busy),
    .per_norm(per_n), .per_fast(per_f), .start(start)
  );

  tsc_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .run(auto_en), .start(start), .adc_valid(adc_valid),
    .adc_req(adc_req), .cur_ch(adc_chan), .smp_v(smp_v), .busy(busy)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_smp[g] = smp_v && (adc_chan == CH_W'(g));
    tsc_chan #(.DW(DW), .DEB_W(DEB_W), .HOT_RISING(HOT_RISING)) u_chan (
      .clk(clk), .rst(rst), .run(auto_en), .smp_v(ch_smp[g]), .raw(adc_code),
      .inv(auto_inv), .al_thr(al_thr[g]), .sh_thr(sh_thr[g]),
      .al_deb(deb_al), .sh_deb(deb_sh), .sh_chk(sh_chk[g]),
      .data(ch_data[g]), .hot(hot[g]), .al_evt(al_evt[g]), .sh_lat(sh_lat[g])
    );
  end

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      user_r   <= '0;
      auto_en  <= 1'b0;
      auto_inv <= 1'b0;
      pol_high <= 1'b0;
      sh_chk   <= '0;
      al_ien   <= '0;
      rt_io    <= '0;
      rt_ru    <= '0;
      deb_al   <= DEB_W'(DEF_DEB);
      deb_sh   <= DEB_W'(DEF_DEB);
      per_n    <= PER_W'(DEF_PER_NORM);
      per_f    <= PER_W'(DEF_PER_FAST);
      for (int c = 0; c < NUM_CH; c++) begin
        al_thr[c] <= THR_RST;
        sh_thr[c] <= THR_RST;
      end
    end else if (wr_en) begin
      case (bus_addr)
        A_USER: user_r <= bus_wdata;
        A_AUTO: begin
          auto_en  <= bus_wdata[B_RUN];
          auto_inv <= bus_wdata[B_INV];
          pol_high <= bus_wdata[B_POLH];
          for (int c = 0; c < NUM_CH; c++) sh_chk[c] <= bus_wdata[B_SHCHK + c];
        end
        A_IEN: begin
          for (int c = 0; c < NUM_CH; c++) begin
            al_ien[c] <= bus_wdata[c];
            rt_io[c]  <= bus_wdata[B_R_IO + c];
            rt_ru[c]  <= bus_wdata[B_R_RU + c];
          end
        end
        A_DEB_AL: deb_al <= bus_wdata[DEB_W-1:0];
        A_DEB_SH: deb_sh <= bus_wdata[DEB_W-1:0];
        A_PER_N:  per_n  <= bus_wdata[PER_W-1:0];
        A_PER_F:  per_f  <= bus_wdata[PER_W-1:0];
        default: begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == chan_addr(G_ALTHR, c)) al_thr[c] <= bus_wdata[DW-1:0];
            if (bus_addr == chan_addr(G_SHTHR, c)) sh_thr[c] <= bus_wdata[DW-1:0];
          end
        end
      endcase
    end
  end

  // alarm pending: event has priority over acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (al_evt[c]) pend[c] <= 1'b1;
        else if (wr_en && (bus_addr == A_PEND) && !bus_wdata[c]) pend[c] <= 1'b0;
      end
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_USER: rd_mux = user_r;
      A_AUTO: begin
        rd_mux[B_RUN]  = auto_en;
        rd_mux[B_INV]  = auto_inv;
        rd_mux[B_POLH] = pol_high;
        for (int c = 0; c < NUM_CH; c++) rd_mux[B_SHCHK + c] = sh_chk[c];
      end
      A_IEN: begin
        for (int c = 0; c < NUM_CH; c++) begin
          rd_mux[c]          = al_ien[c];
          rd_mux[B_R_IO + c] = rt_io[c];
          rd_mux[B_R_RU + c] = rt_ru[c];
        end
      end
      A_PEND: begin
        rd_mux[NUM_CH-1:0] = pend;
        rd_mux[STAT_BIT]   = |sh_lat;
      end
      A_DEB_AL: rd_mux[DEB_W-1:0] = deb_al;
      A_DEB_SH: rd_mux[DEB_W-1:0] = deb_sh;
      A_PER_N:  rd_mux[PER_W-1:0] = per_n;
      A_PER_F:  rd_mux[PER_W-1:0] = per_f;
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (bus_addr == chan_addr(G_DATA, c))  rd_mux[DW-1:0] = ch_data[c];
          if (bus_addr == chan_addr(G_ALTHR, c)) rd_mux[DW-1:0] = al_thr[c];
          if (bus_addr == chan_addr(G_SHTHR, c)) rd_mux[DW-1:0] = sh_thr[c];
        end
      end
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq        <= 1'b0;
      shut_gpio  <= 1'b1;
      shut_reset <= 1'b1;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      irq        <= |(pend & al_ien);
      shut_gpio  <= pol_high ?  (|(sh_lat & rt_io)) : !(|(sh_lat & rt_io));
      shut_reset <= pol_high ?  (|(sh_lat & rt_ru)) : !(|(sh_lat & rt_ru));
    end
  end
endmodule

// File: rtl/thermal_scan_chk.sv
module thermal_scan_chk #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_req,
  input logic [CH_W-1:0]   adc_chan,
  input logic              auto_en,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] sh_lat,
  input logic              smp_v,
  input logic              irq
);
  // R12
  req_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> $past(auto_en));

  // R2
  chan_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> (int'(adc_chan) < NUM_CH));

  // R9
  shut_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((sh_lat & $past(sh_lat)) == $past(sh_lat)));

  // R6
  pend_from_sample_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) != '0) |-> $past(smp_v));

  // R7
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend) == '0) |-> !irq);
endmodule

bind thermal_scan_ctrl thermal_scan_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .adc_req(adc_req), .adc_chan(adc_chan), .auto_en(auto_en),
  .pend(pend), .sh_lat(sh_lat), .smp_v(smp_v), .irq(irq)
);

// File: tb/thermal_scan_ctrl_bench.sv
module thermal_scan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int PN = 20;
  localparam int PF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        adc_req;
  logic [0:0]  adc_chan;
  logic        adc_valid = 1'b0;
  logic [11:0] adc_code = '0;
  logic        irq, shut_gpio, shut_reset;

  int checks = 0, fails = 0, cyc = 0;
  int cnt0 = 0, cnt1 = 0, t0 = 0, exp_ch = 0, order_err = 0;
  logic [11:0] code [2];

  thermal_scan_ctrl #(.TICK_DIV(TDIV)) u_thermal_scan_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_valid(adc_valid), .adc_code(adc_code),
    .irq(irq), .shut_gpio(shut_gpio), .shut_reset(shut_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // ADC stub: answers a request at the following falling edge
  initial forever begin
    @(negedge clk);
    if (adc_req) begin
      adc_valid = 1'b1;
      adc_code  = code[adc_chan];
      if (int'(adc_chan) != exp_ch) order_err++;
      exp_ch = (int'(adc_chan) + 1) % 2;
      if (adc_chan == 1'b0) begin cnt0++; t0 = cyc; end
      else cnt1++;
    end else begin
      adc_valid = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    code[0] = 12'h100; code[1] = 12'h100;
    repeat (3) @(posedge clk);
    exp_ch = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg();
    wr(8'h60, 32'd3);
    wr(8'h64, 32'd2);
    wr(8'h68, PN);
    wr(8'h6C, PF);
    wr(8'h30, 32'h200); wr(8'h34, 32'h200);
    wr(8'h40, 32'h300); wr(8'h44, 32'h300);
  endtask

  task automatic wait_scans(input int n);
    for (int i = 0; i < n; i++) begin
      int m;
      m = cnt1;
      while (cnt1 == m) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic interval(output int d);
    int n, ta;
    n = cnt0;
    while (cnt0 == n) @(posedge clk);
    ta = t0; n = cnt0;
    while (cnt0 == n) @(posedge clk);
    d = t0 - ta;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 shut_gpio", shut_gpio, 1);
    check("R1 shut_reset", shut_reset, 1);
    rd(8'h04, v); check("R1 auto ctl", v, 0);
    rd(8'h60, v); check("R1 debounce default", v, 4);
    rd(8'h0C, v); check("R1 pending", v, 0);
    repeat (100) @(posedge clk);
    check("R1 no request", cnt0 + cnt1, 0);
  endtask

  task automatic t_scan();
    logic [31:0] v;
    do_reset(); cfg();
    code[0] = 12'h8AB; code[1] = 12'h123;
    wr(8'h04, 32'h1);
    wait_scans(2);
    rd(8'h20, v); check("R2 ch0 masked", v, 32'h8AB & 32'h3FF);
    rd(8'h24, v); check("R2 ch1 data", v, 32'h123);
    check("R2 channel order", order_err, 0);
  endtask

  task automatic t_invert();
    logic [31:0] v;
    do_reset(); cfg();
    code[0] = 12'h405; code[1] = 12'h000;
    wr(8'h04, 32'h3);
    wait_scans(1);
    rd(8'h20, v); check("R3 inverted ch0", v, (1024 - (32'h405 & 32'h3FF)) & 32'h3FF);
    rd(8'h24, v); check("R3 inverted zero", v, 1024 & 32'h3FF);
  endtask

  task automatic t_period();
    int d;
    do_reset(); cfg();
    wr(8'h04, 32'h1);
    interval(d); check("R4 normal period", d, PN * TDIV);
    code[1] = 12'h250;
    wait_scans(1);
    interval(d); check("R4 fast period", d, PF * TDIV);
    code[1] = 12'h200;
    wait_scans(1);
    interval(d); check("R5 equal is not hot", d, PN * TDIV);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    do_reset(); cfg();
    wr(8'h08, 32'h1);
    code[0] = 12'h250; code[1] = 12'h250;
    wr(8'h04, 32'h1);
    wait_scans(2);
    rd(8'h0C, v); check("R6 before count", v, 0);
    check("R7 irq idle", irq, 0);
    wait_scans(1);
    rd(8'h0C, v); check("R6 at count", v, 3);
    check("R7 irq raised", irq, 1);
    code[0] = 12'h100; code[1] = 12'h100;
    wait_scans(1);
    wr(8'h0C, 32'h2);
    rd(8'h0C, v); check("R8 ack ch0 only", v, 2);
    @(negedge clk);
    check("R7 masked pending", irq, 0);
    wr(8'h0C, 32'h0);
    code[0] = 12'h250;
    wait_scans(2);
    code[0] = 12'h100;
    wait_scans(1);
    code[0] = 12'h250;
    wait_scans(2);
    rd(8'h0C, v); check("R6 run restarted", v, 0);
    wait_scans(1);
    rd(8'h0C, v); check("R6 fires after restart", v, 1);
  endtask

  task automatic t_shut_gpio();
    logic [31:0] v;
    do_reset(); cfg();
    wr(8'h08, (1 << 5) | (1 << 8));
    code[0] = 12'h350; code[1] = 12'h350;
    wr(8'h04, 32'h1 | (1 << 5));
    wait_scans(1);
    check("R9 before count", shut_gpio, 1);
    wait_scans(1);
    check("R10 gpio active low", shut_gpio, 0);
    check("R9 unchecked ch0 no shutdown", shut_reset, 1);
    code[0] = 12'h100; code[1] = 12'h100;
    rd(8'h0C, v); check("R8 status bit", v, 32'h1_0000);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); check("R8 status ignores write", v, 32'h1_0000);
    wait_scans(1);
    check("R9 sticky", shut_gpio, 0);
  endtask

  task automatic t_shut_polarity();
    do_reset(); cfg();
    wr(8'h08, 32'h100);
    wr(8'h04, 32'h1 | (1 << 4) | (1 << 8));
    @(negedge clk);
    check("R11 idle high-pol reset pin", shut_reset, 0);
    check("R11 idle high-pol gpio pin", shut_gpio, 0);
    code[0] = 12'h350;
    wait_scans(2);
    check("R11 reset pin active high", shut_reset, 1);
    check("R10 gpio unrouted", shut_gpio, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    int n, ts;
    do_reset(); cfg();
    wr(8'h08, 32'h1);
    code[0] = 12'h250;
    wr(8'h04, 32'h1);
    wait_scans(2);
    wr(8'h04, 32'h0);
    n = cnt0;
    repeat (300) @(posedge clk);
    check("R12 no requests", cnt0, n);
    rd(8'h20, v); check("R12 data kept", v, 32'h250);
    n = cnt0;
    wr(8'h04, 32'h1);
    ts = cyc;
    while (cnt0 == n) @(posedge clk);
    check("R12 normal period after enable", (t0 - ts) >= (PN * TDIV - 4), 1);
    wait_scans(2);
    rd(8'h0C, v); check("R12 counts cleared", v, 0);
    wait_scans(1);
    rd(8'h0C, v); check("R12 full count", v, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    summary();
  end

  initial begin
    code[0] = 12'h100; code[1] = 12'h100;
    t_reset();
    t_scan();
    t_invert();
    t_period();
    t_alarm();
    t_shut_gpio();
    t_shut_polarity();
    t_disable();
    summary();
  end
endmodule